// File: doc/BRIEF.md
# Attenuator Mode and Power-Up Controller

This block decides which 5-bit attenuation code drives a stepped attenuator. The code is plain binary in decibels: bit 0 is worth 1 dB, bit 1 is 2 dB, bit 2 is 4 dB, bit 3 is 8 dB and bit 4 is 16 dB. A value of 0 is the reference (minimum) loss and 31 is the maximum. The code comes either from five parallel control pins or from the raw contents of an external serial shift register. A mode pin picks the source. A latch-enable pin makes a holding stage transparent (high) or holds it (low). In parallel mode, holding latch enable high gives direct mode. Pulsing it high then low gives latched mode.

When reset is released, the block places a known code on the output before any control word arrives. It samples the mode and latch-enable levels once, on the first clock edge after reset. In parallel mode with latch enable low, two select pins pick one of four preset codes. In every other case the initial code is copied from the parallel pins. After that edge the pins act live. A rate guard makes the output change at most once every `MIN_GAP` clocks. A request that comes in earlier waits, and the newest request is applied when the interval ends.

Top module: `attn_mode_ctrl`

## Requirements
- R1: While `rstN` is low, `attnCode` is 0 (reference loss).
- R2: At the first clock edge after reset release with `serSel`=0 and `latchEn`=0, `attnCode` takes a value from `pwrSel`: 00 gives 0, 01 gives 8, 10 gives 16, 11 gives 31.
- R3: At the first clock edge after reset release with `serSel`=0 and `latchEn`=1, `attnCode` takes `parCode`, and `pwrSel` has no effect.
- R4: At the first clock edge after reset release with `serSel`=1, `attnCode` takes `parCode`, whatever the level of `latchEn`.
- R5: In parallel mode (`serSel`=0) with `latchEn` high, a new `parCode` appears on `attnCode` at the next clock edge once the rate guard allows it.
- R6: In parallel mode with `latchEn` low, `parCode` changes have no effect. A clock edge that sees `latchEn` high captures `parCode`, and the captured value stays after `latchEn` falls.
- R7: In serial mode (`serSel`=1), `attnCode` follows `serCode` while `latchEn` is high and keeps the last captured value while `latchEn` is low.
- R8: Two changes of `attnCode` (the power-up load included) are at least `MIN_GAP` clock cycles apart.
- R9: A request held back by the rate guard is applied at the first edge the guard allows, using the newest requested value. Outside the power-up load and a permitted update, `attnCode` does not change.
- R10: The power-up choice is made only once per reset. Later changes of `pwrSel` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; release models power-up |
| serSel | input | 1 | Source select: 0 parallel pins, 1 serial register |
| latchEn | input | 1 | High: holding stage transparent; low: hold |
| parCode | input | CW | Parallel attenuation code (bit i weighs 2^i dB) |
| pwrSel | input | 2 | Power-up preset select |
| serCode | input | CW | Raw contents of the external serial shift register |
| attnCode | output | CW | Attenuation code applied to the attenuator |

## Verification
Some properties are checked on every cycle: the reset value, the spacing of output changes, and output stability when no load strobe is given. Also checked each cycle: after a load strobe the output equals the source that the mode and latch-enable levels select, and the power-up load lands on one of the four presets or on the parallel pins. Other behaviour only shows up in the bench scenarios. These are: a latched capture after a short latch-enable pulse, pins ignored while latch enable is low, `pwrSel` ignored after power-up, and the newest pending value winning when the guard window closes. A random phase compares every cycle against a bench model of the requirements while modes and latch enable switch freely.

// File: rtl/attn_pkg.sv
package attn_pkg;
  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic initLoad;  // apply the power-up code
    logic holdLoad;  // holding stage transparent this cycle
    logic outLoad;   // rate guard allows an output update
  } attnStrb_t;
endpackage

// File: rtl/attn_ctrl.sv
module attn_ctrl
  import attn_pkg::*;
#(
  parameter int MIN_GAP = 4000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      latchEn,
  input  logic      codeDiff,
  output attnStrb_t strb
);
  localparam int GW = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
  localparam logic [GW-1:0] GAP_TOP = GW'(MIN_GAP - 1);

  logic          started;
  logic [GW-1:0] gapCnt;
  logic          ready;

  assign ready         = (gapCnt == '0);
  assign strb.initLoad = !started;
  assign strb.holdLoad = started && latchEn;
  assign strb.outLoad  = started && ready && codeDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      gapCnt  <= '0;
    end else begin
      if (!started) started <= 1'b1;
      if (strb.initLoad || strb.outLoad) gapCnt <= GAP_TOP;
      else if (!ready)                   gapCnt <= gapCnt - 1'b1;
    end
  end
endmodule

// File: rtl/attn_path.sv
module attn_path
  import attn_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serSel,
  input  logic          latchEn,
  input  logic [CW-1:0] parCode,
  input  logic [CW-1:0] serCode,
  input  logic [1:0]    pwrSel,
  input  attnStrb_t     strb,
  output logic          codeDiff,
  output logic [CW-1:0] attnCode
);
  localparam logic [CW-1:0] PRE_ZERO = '0;
  localparam logic [CW-1:0] PRE_QTR  = CW'(1) << (CW - 2);
  localparam logic [CW-1:0] PRE_HALF = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] PRE_MAX  = '1;

  logic [CW-1:0] holdCode, srcCode, tgtCode, presetCode, initCode;

  assign srcCode = serSel ? serCode : parCode;
  assign tgtCode = latchEn ? srcCode : holdCode;

  always_comb begin
    unique case (pwrSel)
      2'b00:   presetCode = PRE_ZERO;
      2'b01:   presetCode = PRE_QTR;
      2'b10:   presetCode = PRE_HALF;
      default: presetCode = PRE_MAX;
    endcase
  end

  assign initCode = (!serSel && !latchEn) ? presetCode : parCode;
  assign codeDiff = (tgtCode != attnCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCode <= '0;
      attnCode <= '0;
    end else if (strb.initLoad) begin
      holdCode <= initCode;
      attnCode <= initCode;
    end else begin
      if (strb.holdLoad) holdCode <= srcCode;
      if (strb.outLoad)  attnCode <= tgtCode;
    end
  end
endmodule

// File: rtl/attn_mode_ctrl.sv
module attn_mode_ctrl
  import attn_pkg::*;
#(
  parameter int CW      = 5,
  parameter int MIN_GAP = 4000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serSel,
  input  logic          latchEn,
  input  logic [CW-1:0] parCode,
  input  logic [1:0]    pwrSel,
  input  logic [CW-1:0] serCode,
  output logic [CW-1:0] attnCode
);
  attnStrb_t strb;
  logic      codeDiff;

  attn_ctrl #(.MIN_GAP(MIN_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .latchEn(latchEn),
    .codeDiff(codeDiff), .strb(strb)
  );

  attn_path #(.CW(CW)) u_path (
    .clk(clk), .rstN(rstN), .serSel(serSel), .latchEn(latchEn),
    .parCode(parCode), .serCode(serCode), .pwrSel(pwrSel),
    .strb(strb), .codeDiff(codeDiff), .attnCode(attnCode)
  );
endmodule

// File: rtl/attn_mode_chk.sv
module attn_mode_chk
  import attn_pkg::*;
#(
  parameter int CW      = 5,
  parameter int MIN_GAP = 4000
) (
  input logic          clk,
  input logic          rstN,
  input logic          serSel,
  input logic          latchEn,
  input logic [CW-1:0] parCode,
  input logic [1:0]    pwrSel,
  input logic [CW-1:0] serCode,
  input logic [CW-1:0] attnCode,
  input attnStrb_t     strb
);
  localparam int SW = $clog2(MIN_GAP + 1);
  localparam logic [SW-1:0] SAT = SW'(MIN_GAP);

  logic [CW-1:0] prevCode;
  logic [SW-1:0] sinceChg;
  logic          changed;

  assign changed = (attnCode != prevCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode <= '0;
      sinceChg <= SAT;
    end else begin
      prevCode <= attnCode;
      if (changed)             sinceChg <= SW'(1);
      else if (sinceChg < SAT) sinceChg <= sinceChg + 1'b1;
    end
  end

  // R1
  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |=> attnCode == '0);

  // R2
  a_r2_preset_code: assert property (@(posedge clk) disable iff (!rstN)
    strb.initLoad && !serSel && !latchEn |=>
      (attnCode == '0 || attnCode == (CW'(1) << (CW-2)) ||
       attnCode == (CW'(1) << (CW-1)) || attnCode == '1));

  // R3 and R4
  a_r3_init_from_pins: assert property (@(posedge clk) disable iff (!rstN)
    strb.initLoad && (serSel || latchEn) |=> attnCode == $past(parCode));

  // R5
  a_r5_direct_follow: assert property (@(posedge clk) disable iff (!rstN)
    strb.outLoad && !serSel && latchEn |=> attnCode == $past(parCode));

  // R7
  a_r7_serial_follow: assert property (@(posedge clk) disable iff (!rstN)
    strb.outLoad && serSel && latchEn |=> attnCode == $past(serCode));

  // R8
  a_r8_min_gap: assert property (@(posedge clk) disable iff (!rstN)
    changed |-> sinceChg >= SAT);

  // R9
  a_r9_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !strb.initLoad && !strb.outLoad |=> $stable(attnCode));

  // R10
  a_r10_single_init: assert property (@(posedge clk) disable iff (!rstN)
    strb.initLoad |=> !strb.initLoad);
endmodule

bind attn_mode_ctrl attn_mode_chk #(.CW(CW), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rstN(rstN), .serSel(serSel), .latchEn(latchEn),
  .parCode(parCode), .pwrSel(pwrSel), .serCode(serCode),
  .attnCode(attnCode), .strb(strb)
);

// File: tb/tb_attn_mode_ctrl.sv
module tb_attn_mode_ctrl;
  localparam int CW  = 5;
  localparam int GAP = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          serSel = 1'b0, latchEn = 1'b0;
  logic [CW-1:0] parCode = '0, serCode = '0;
  logic [1:0]    pwrSel = '0;
  logic [CW-1:0] attnCode;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit modelOn = 1'b0;

  always #5 clk = ~clk;

  attn_mode_ctrl #(.CW(CW), .MIN_GAP(GAP)) dut (
    .clk(clk), .rstN(rstN), .serSel(serSel), .latchEn(latchEn),
    .parCode(parCode), .pwrSel(pwrSel), .serCode(serCode),
    .attnCode(attnCode)
  );

  function automatic logic [CW-1:0] presetOf(input logic [1:0] s);
    case (s)
      2'b00:   return 5'd0;
      2'b01:   return 5'd8;
      2'b10:   return 5'd16;
      default: return 5'd31;
    endcase
  endfunction

  function automatic logic [CW-1:0] initOf(input logic ps, input logic le,
                                           input logic [1:0] s, input logic [CW-1:0] p);
    return (!ps && !le) ? presetOf(s) : p;
  endfunction

  // Bench model built from the requirements
  logic          mStarted;
  logic [CW-1:0] mOut, mHold;
  int            mWait;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStarted <= 1'b0; mOut <= '0; mHold <= '0; mWait <= 0;
    end else if (!mStarted) begin
      mStarted <= 1'b1;
      mOut  <= initOf(serSel, latchEn, pwrSel, parCode);
      mHold <= initOf(serSel, latchEn, pwrSel, parCode);
      mWait <= GAP - 1;
    end else begin
      logic [CW-1:0] src, tgt;
      src = serSel ? serCode : parCode;
      tgt = latchEn ? src : mHold;
      if (latchEn) mHold <= src;
      if (mWait == 0 && tgt != mOut) begin
        mOut <= tgt; mWait <= GAP - 1;
      end else if (mWait != 0) mWait <= mWait - 1;
    end
  end

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic powerUp(input string tag, input logic ps, input logic le,
                         input logic [1:0] s, input logic [CW-1:0] p,
                         input logic [CW-1:0] exp);
    @(negedge clk);
    rstN = 1'b0; serSel = ps; latchEn = le; pwrSel = s; parCode = p;
    serCode = ~p;
    cycles(2);
    check("R1 reset value", attnCode, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(tag, attnCode, exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    cycles(2);
    check("R1 reset at start", attnCode, '0);

    powerUp("R2 preset 00", 1'b0, 1'b0, 2'b00, 5'd21, 5'd0);
    powerUp("R2 preset 01", 1'b0, 1'b0, 2'b01, 5'd21, 5'd8);
    powerUp("R2 preset 10", 1'b0, 1'b0, 2'b10, 5'd21, 5'd16);
    powerUp("R2 preset 11", 1'b0, 1'b0, 2'b11, 5'd2, 5'd31);
    powerUp("R3 direct init ignores pwrSel", 1'b0, 1'b1, 2'b11, 5'd21, 5'd21);
    powerUp("R4 serial init LE low", 1'b1, 1'b0, 2'b01, 5'd13, 5'd13);
    powerUp("R4 serial init LE high", 1'b1, 1'b1, 2'b10, 5'd6, 5'd6);

    // Latched parallel: power up to 8, then pins ignored until LE pulse
    powerUp("R2 preset before latch test", 1'b0, 1'b0, 2'b01, 5'd0, 5'd8);
    parCode = 5'd19;
    cycles(GAP + 3);
    check("R6 pins ignored while LE low", attnCode, 5'd8);
    pwrSel = 2'b11;
    cycles(3);
    check("R10 pwrSel ignored after power-up", attnCode, 5'd8);
    latchEn = 1'b1;
    @(negedge clk);
    latchEn = 1'b0;
    check("R6 LE pulse captures", attnCode, 5'd19);
    parCode = 5'd2;
    cycles(GAP + 3);
    check("R6 captured value kept", attnCode, 5'd19);

    // Direct parallel and rate guard
    latchEn = 1'b1; parCode = 5'd7;
    @(negedge clk);
    check("R5 direct update next edge", attnCode, 5'd7);
    parCode = 5'd9;
    @(negedge clk);
    parCode = 5'd12;
    cycles(GAP - 2);
    check("R8 held inside interval", attnCode, 5'd7);
    @(negedge clk);
    check("R9 newest value at interval end", attnCode, 5'd12);

    // Serial
    cycles(GAP + 2);
    serSel = 1'b1; serCode = 5'd22;
    @(negedge clk);
    check("R7 serial follows while LE high", attnCode, 5'd22);
    latchEn = 1'b0; serCode = 5'd3;
    cycles(GAP + 2);
    check("R7 serial holds while LE low", attnCode, 5'd22);

    // Random phase against model
    modelOn = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) parCode = CW'($urandom);
      if ($urandom_range(0, 3) == 0) serCode = CW'($urandom);
      if ($urandom_range(0, 9) == 0) latchEn = ~latchEn;
      if ($urandom_range(0, 29) == 0) serSel = ~serSel;
      if ($urandom_range(0, 19) == 0) pwrSel = 2'($urandom);
      if ($urandom_range(0, 499) == 0) begin
        rstN = 1'b0;
        @(negedge clk);
        rstN = 1'b1;
      end
      @(negedge clk);
      check("R9 random vs model", attnCode, mOut);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule